// File: doc/BRIEF.md
# Signature-Row Read Window

This block is the control-register slice of a small microcontroller's self-programming unit. It decides, cycle by cycle, whether a program-memory load instruction returns normal flash data or a byte from a small factory row. That row holds identity bytes and oscillator and bandgap calibration bytes. The CPU arms the mode by writing the control register with two bits set: the signature-select bit and the self-program-enable bit. This opens a short, self-closing window.

A load issued during the first three cycles of the window takes its byte from the factory row, selected by the load address. A load issued later in the window returns flash data, even though the arming bits still read back as set. Six cycles after the arming write, both arming bits clear by themselves. The register ignores CPU writes until they have cleared. A write that sets only one of the two bits is stored as an ordinary register value and opens no window.

Top module: `sig_read_window`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x00, no window is open and the register accepts writes.
- R2: A write whose data has bit 0 (self-program enable) and bit 5 (signature select) both set arms the window. Both bits read back set for the next 6 cycles and read back clear from the 7th cycle after the write.
- R3: While the window is open, a CPU write to the control register has no effect on its readback.
- R4: A load request in cycle 1, 2 or 3 after the arming write returns the factory-row byte at the load address.
- R5: A load request in cycle 4, 5 or 6 after the arming write returns the flash read data.
- R6: With no window open, a load returns the flash read data.
- R7: Factory-row addresses 0x00 to 0x0B and 0x11 return their stored bytes: identity bytes at 0x00, 0x02 and 0x04, oscillator bytes at 0x01 and 0x03, slow and ultra-low-power RC bytes at 0x05 to 0x0A, and bandgap bytes at 0x0B and 0x11.
- R8: A factory-row load from a reserved address (0x0C to 0x10) or from any address of 0x12 or above returns 0xFF.
- R9: A write that sets only one of bits 0 and 5 is stored as written, opens no window and does not lock the register.
- R10: Reset during an open window clears both arming bits, closes the window and unlocks the register.
- R11: The automatic clear touches only bits 0 and 5. All other register bits keep the value written at arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_we | input | 1 | CPU write strobe for the control register |
| ctl_wdata | input | 8 | CPU write data |
| ctl_rdata | output | 8 | Control register readback |
| ld_req | input | 1 | Program-memory load request |
| ld_addr | input | 16 | Load address (pointer register) |
| flash_rdata | input | 8 | Normal flash read data for ld_addr |
| ld_data | output | 8 | Byte returned to the load instruction |

## Verification
The bench arms the window once for each base address across the whole row and beyond it. In every window it probes all six cycles and the first cycle after the window. A design with a window limit that is off by one would return a factory byte in cycle 4, or flash data in cycle 3. A counter that clears one cycle early or late shows up in the readback at cycle 6 or cycle 7. A lock test writes zero in the middle of the window and catches a register that accepts it. A clear that wipes the whole register is caught by a high bit that must survive. Reserved and far-out addresses catch a row that leaks stored or stale bytes instead of 0xFF. Single-bit writes and a reset in the middle of a window catch arming that decodes only one bit, and a lock that outlives reset.

// File: rtl/sigwin_pkg.sv
package sigwin_pkg;
  localparam int unsigned WORD_W    = 8;
  localparam int unsigned ROW_COUNT = 18;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned SIG_BIT   = 5;
  localparam logic [WORD_W-1:0] BLANK_BYTE = '1;

  typedef logic [WORD_W-1:0] byte_t;

  // Both enable and select set in the same write opens the window.
  function automatic logic is_arming(input byte_t d);
    return d[EN_BIT] & d[SIG_BIT];
  endfunction

  // Holes in the factory row read as blank.
  function automatic logic is_reserved(input int unsigned idx);
    return (idx >= 32'd12) && (idx <= 32'd16);
  endfunction

  // Mask that removes only the arming bits.
  function automatic byte_t disarm(input byte_t d);
    byte_t m;
    m = '1;
    m[EN_BIT]  = 1'b0;
    m[SIG_BIT] = 1'b0;
    return d & m;
  endfunction
endpackage

// File: rtl/sigwin_timer.sv
module sigwin_timer #(
  parameter int unsigned WIN_CYCLES  = 6,
  parameter int unsigned LOAD_CYCLES = 3,
  localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_evt,
  output logic [CNT_W-1:0] win_cnt,
  output logic             win_lock,
  output logic             win_expire,
  output logic             load_ok
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (arm_evt)                        cnt_q <= CNT_W'(1);
    else if (cnt_q == CNT_W'(WIN_CYCLES))    cnt_q <= '0;
    else if (cnt_q != '0)                    cnt_q <= cnt_q + CNT_W'(1);
  end

  assign win_cnt    = cnt_q;
  assign win_lock   = (cnt_q != '0);
  assign win_expire = (cnt_q == CNT_W'(WIN_CYCLES));
  assign load_ok    = (cnt_q != '0) && (cnt_q <= CNT_W'(LOAD_CYCLES));
endmodule

// File: rtl/sigwin_ctl_reg.sv
module sigwin_ctl_reg
  import sigwin_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  byte_t wdata,
  input  logic  lock,
  input  logic  expire,
  output byte_t q,
  output logic  arm_evt
);
  byte_t  q_r;
  logic   wr_ok;

  assign wr_ok   = we & ~lock;
  assign arm_evt = wr_ok & is_arming(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)      q_r <= '0;
    else if (wr_ok)  q_r <= wdata;
    else if (expire) q_r <= disarm(q_r);
  end

  assign q = q_r;
endmodule

// File: rtl/sigwin_rom.sv
module sigwin_rom
  import sigwin_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ROW_COUNT*WORD_W-1:0] ROM_INIT = '0,
  localparam int unsigned IDX_W = $clog2(ROW_COUNT)
) (
  input  logic [ADDR_W-1:0] addr,
  output byte_t             rdata
);
  byte_t      row [ROW_COUNT];
  logic       in_range;
  logic [IDX_W-1:0] idx;

  for (genvar i = 0; i < ROW_COUNT; i++) begin : g_row
    if (is_reserved(i)) begin : g_hole
      assign row[i] = BLANK_BYTE;
    end else begin : g_cell
      assign row[i] = ROM_INIT[i*WORD_W +: WORD_W];
    end
  end

  assign in_range = (addr < ADDR_W'(ROW_COUNT));
  assign idx      = addr[IDX_W-1:0];
  assign rdata    = in_range ? row[idx] : BLANK_BYTE;
endmodule

// File: rtl/sigwin_mux.sv
module sigwin_mux
  import sigwin_pkg::*;
(
  input  logic  ld_req,
  input  logic  load_ok,
  input  byte_t rom_byte,
  input  byte_t flash_byte,
  output byte_t ld_data,
  output logic  sig_hit
);
  assign sig_hit = ld_req & load_ok;
  assign ld_data = sig_hit ? rom_byte : flash_byte;
endmodule

// File: rtl/sig_read_window.sv
module sig_read_window
  import sigwin_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned WIN_CYCLES  = 6,
  parameter int unsigned LOAD_CYCLES = 3,
  parameter logic [ROW_COUNT*WORD_W-1:0] ROM_INIT =
    {8'h5C, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h61, 8'h0E, 8'h8A,
     8'h12, 8'h34, 8'hE8, 8'h03, 8'h02, 8'h02, 8'h10, 8'h93, 8'h1E},
  localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        flash_rdata,
  output logic [7:0]        ld_data
);
  // Named internal events, visible to the bound checker.
  logic             arm_evt;
  logic [CNT_W-1:0] win_cnt;
  logic             win_lock;
  logic             win_expire;
  logic             load_ok;
  logic             sig_hit;
  byte_t            rom_byte;

  sigwin_timer #(.WIN_CYCLES(WIN_CYCLES), .LOAD_CYCLES(LOAD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm_evt(arm_evt), .win_cnt(win_cnt),
    .win_lock(win_lock), .win_expire(win_expire), .load_ok(load_ok)
  );

  sigwin_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .lock(win_lock), .expire(win_expire), .q(ctl_rdata), .arm_evt(arm_evt)
  );

  sigwin_rom #(.ADDR_W(ADDR_W), .ROM_INIT(ROM_INIT)) u_rom (
    .addr(ld_addr), .rdata(rom_byte)
  );

  sigwin_mux u_mux (
    .ld_req(ld_req), .load_ok(load_ok), .rom_byte(rom_byte),
    .flash_byte(flash_rdata), .ld_data(ld_data), .sig_hit(sig_hit)
  );
endmodule

// File: rtl/sigwin_chk.sv
module sigwin_chk
  import sigwin_pkg::*;
#(
  parameter int unsigned WIN_CYCLES  = 6,
  parameter int unsigned LOAD_CYCLES = 3,
  localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [7:0]       ctl_wdata,
  input logic [7:0]       ctl_rdata,
  input logic [7:0]       flash_rdata,
  input logic [7:0]       ld_data,
  input logic             arm_evt,
  input logic [CNT_W-1:0] win_cnt,
  input logic             sig_hit
);
  // R1 / R10: reset leaves a cleared, unlocked register
  a_r10_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (ctl_rdata == 8'h00) && (win_cnt == '0));

  // R2: an accepted arming write starts the window at cycle 1
  a_r2_arm_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (win_cnt == '0) && ctl_wdata[EN_BIT] && ctl_wdata[SIG_BIT])
      |=> (win_cnt == CNT_W'(1)) && (ctl_rdata == $past(ctl_wdata)));

  // R2 / R11: last window cycle clears only the arming bits
  a_r2_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt == CNT_W'(WIN_CYCLES)) |=>
      (ctl_rdata == disarm($past(ctl_rdata))) && (win_cnt == '0));

  // R3: writes inside the window do not reach the register
  a_r3_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (win_cnt != '0) && (win_cnt != CNT_W'(WIN_CYCLES)))
      |=> $stable(ctl_rdata));

  // R4 / R5: signature data only in the early part of the window
  a_r4_hit_early: assert property (@(posedge clk) disable iff (!rst_n)
    sig_hit |-> (win_cnt != '0) && (win_cnt <= CNT_W'(LOAD_CYCLES)));

  // R5 / R6: outside the early part, loads see flash
  a_r6_flash_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_cnt == '0) || (win_cnt > CNT_W'(LOAD_CYCLES))) |-> (ld_data == flash_rdata));

  // R9: a single-bit write never opens the window
  a_r9_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !(ctl_wdata[EN_BIT] && ctl_wdata[SIG_BIT]) && (win_cnt == '0))
      |=> (win_cnt == '0));

  // R2: arm event and window start agree
  a_r2_arm_evt: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt |=> (ctl_rdata[EN_BIT] && ctl_rdata[SIG_BIT]));
endmodule

bind sig_read_window sigwin_chk #(.WIN_CYCLES(WIN_CYCLES), .LOAD_CYCLES(LOAD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .flash_rdata(flash_rdata), .ld_data(ld_data),
  .arm_evt(arm_evt), .win_cnt(win_cnt), .sig_hit(sig_hit)
);

// File: tb/tb_sig_read_window.sv
`timescale 1ns/1ps
module tb_sig_read_window;
  localparam int ROWS = 18;

  function automatic logic [ROWS*8-1:0] mk_rom();
    logic [ROWS*8-1:0] v;
    v = '0;
    for (int i = 0; i < ROWS; i++) v[i*8 +: 8] = 8'((i * 37 + 11) % 256);
    return v;
  endfunction
  localparam logic [ROWS*8-1:0] TB_ROM = mk_rom();

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = 8'h00;
  logic [7:0]  ctl_rdata;
  logic        ld_req = 1'b0;
  logic [15:0] ld_addr = 16'h0;
  logic [7:0]  flash_rdata = 8'h00;
  logic [7:0]  ld_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sig_read_window #(.ROM_INIT(TB_ROM)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ld_req(ld_req), .ld_addr(ld_addr),
    .flash_rdata(flash_rdata), .ld_data(ld_data)
  );

  // Expected factory byte: holes and far addresses read 0xFF (R7, R8).
  function automatic logic [7:0] exp_row(input logic [15:0] a);
    if (a >= 16'd18) return 8'hFF;
    if (a >= 16'd12 && a <= 16'd16) return 8'hFF;
    return 8'((int'(a) * 37 + 11) % 256);
  endfunction

  function automatic logic [7:0] flash_of(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // Present a load in the current cycle and sample it before the next edge.
  task automatic load(input logic [15:0] a);
    ld_req = 1'b1;
    ld_addr = a;
    flash_rdata = flash_of(a);
    #1;
  endtask

  task automatic write(input logic [7:0] d);
    ctl_we = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset readback", ctl_rdata, 8'h00);
    load(16'h0002);
    check("R6 idle load flash", ld_data, flash_of(16'h0002));

    // Sweep the window over every row address and past the end.
    for (int a = 0; a < 22; a++) begin
      write(8'hA1);                                    // age 1
      load(16'(a));
      check("R4 R7 R8 age1 row", ld_data, exp_row(16'(a)));
      check("R2 bits set", ctl_rdata, 8'hA1);
      ctl_we = 1'b1; ctl_wdata = 8'h00;                // write during lock
      @(negedge clk);                                  // age 2
      ctl_we = 1'b0;
      load(16'(a + 1));
      check("R4 age2 row", ld_data, exp_row(16'(a + 1)));
      check("R3 locked write ignored", ctl_rdata, 8'hA1);
      @(negedge clk);                                  // age 3
      load(16'(a + 2));
      check("R4 age3 row", ld_data, exp_row(16'(a + 2)));
      for (int k = 4; k <= 6; k++) begin
        @(negedge clk);
        load(16'(a));
        check("R5 late window flash", ld_data, flash_of(16'(a)));
        check("R2 bits held", ctl_rdata, 8'hA1);
      end
      @(negedge clk);                                  // age 7
      load(16'(a));
      check("R2 R11 autoclear", ctl_rdata, 8'h80);
      check("R6 after window flash", ld_data, flash_of(16'(a)));
    end

    // Far address with high byte set.
    write(8'h21);
    load(16'h1203);
    check("R8 far address", ld_data, 8'hFF);
    repeat (6) @(negedge clk);
    check("R2 clear no extras", ctl_rdata, 8'h00);

    // R9: single-bit writes store, do not lock, do not redirect.
    write(8'h20);
    load(16'h0000);
    check("R9 select-only stored", ctl_rdata, 8'h20);
    check("R9 select-only no window", ld_data, flash_of(16'h0000));
    write(8'h01);
    load(16'h0004);
    check("R9 enable-only accepted", ctl_rdata, 8'h01);
    check("R9 enable-only no window", ld_data, flash_of(16'h0004));
    write(8'h00);
    #1;
    check("R9 unlocked", ctl_rdata, 8'h00);

    // R10: reset in the middle of a window.
    write(8'h61);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    load(16'h0000);
    check("R10 bits cleared", ctl_rdata, 8'h00);
    check("R10 window closed", ld_data, flash_of(16'h0000));
    write(8'h40);
    #1;
    check("R10 unlocked", ctl_rdata, 8'h40);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule